// File: doc/BRIEF.md
# UART Host Register File with Multiprocessor Status

This block is the byte-wide host side of a UART that can run in a multiprocessor mode, where a ninth bit on each character marks it as an address character. A host reaches it through a small register bus: a two-bit address, read and write strobes, write data and combinational read data. One address carries data in both directions. A write there loads the transmit holding byte, and a read there returns the last received byte.

Two status registers sit beside the data address. The line status register shows three things: whether the transmit holding register can take another byte, whether the transmitter has fully drained, and the synchronised level of the active-low clear-to-send input. The multiprocessor status register shows the ninth bit of the latest received character. It also raises a new-frame flag when the byte in the receive register is the first data byte after an address character. Both of these receive flags clear when the host reads the data address.

The serial engines sit outside this block. The transmit engine sees the holding byte and its full flag. It pulses `tx_take` when it moves that byte into its shift register, and it holds `tx_shift_busy` high while a character is on the line, stop bit included. The receive engine pulses `rx_strobe` with the completed byte and its ninth bit.

Top module: `uart_mp_regs`

## Requirements
- R1: Line status bit 0 (holding empty) reads 1 after reset. It reads 0 from the cycle after a bus write to address 0.
- R2: Holding empty returns to 1 the cycle after `tx_take` is high. If a write to address 0 happens in the same cycle as `tx_take`, the write wins and the flag stays 0.
- R3: Line status bit 1 (transmitter idle) reads 1 only when holding empty is 1 and `tx_shift_busy` is 0. It reads 1 after reset.
- R4: Line status bit 2 returns the level of `cts_n` through a two-flop synchronizer, so a change shows on reads two clock edges later. The synchroniser resets to 1.
- R5: Multiprocessor status bit 0 holds the ninth bit of the most recently received character. It resets to 0.
- R6: Multiprocessor status bit 1 (new frame) is set when a character with ninth bit 0 arrives and the character before it had ninth bit 1. Any other arrival clears it. Host reads do not disturb the pending address marker.
- R7: A read of address 0 returns the last received byte and clears both multiprocessor status bits on that clock edge. A write to address 0 does not change the received byte.
- R8: When a read of address 0 and `rx_strobe` happen in the same cycle, the flags take the values of the new character.
- R9: Bits 7:2 of the multiprocessor status register, bits 7:3 of the line status register, and all of address 3 read 0. Writes to addresses 1 to 3 change no state.
- R10: `tx_hold_data` shows the byte from the last write to address 0. `tx_hold_full` is the inverse of holding empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 line status, 2 multiprocessor status, 3 spare |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| cts_n | input | 1 | Asynchronous clear-to-send, active low |
| tx_hold_data | output | 8 | Transmit holding byte for the engine |
| tx_hold_full | output | 1 | Holding register holds a byte not yet taken |
| tx_take | input | 1 | Engine moves the holding byte into its shift register |
| tx_shift_busy | input | 1 | Engine is shifting a character out |
| rx_strobe | input | 1 | Engine delivers a completed character |
| rx_data | input | 8 | Received byte |
| rx_mp_bit | input | 1 | Ninth bit of the received character |

## Verification
The bench drives a write and a take in the same cycle. A design that let the take win would report the holding register empty while a byte is still unsent. It collides a data-address read with an arriving address character. Here, favouring the read would lose the multiprocessor bit. It places host reads between an address character and the following data byte. A design that cleared the pending marker on a read would miss the new-frame flag. Random traffic also checks that the clear-to-send bit lags its input by exactly two edges, and that reserved bits and writes to the status addresses never show up.

// File: rtl/uart_mp_pkg.sv
// Package: register selects and status bit positions shared by the
// register file, its submodules and its checker.
package uart_mp_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA   = 2'd0,
        SEL_LINE   = 2'd1,
        SEL_MPSTAT = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    // Bit positions inside the line status register.
    localparam int LINE_HOLD_EMPTY = 0;
    localparam int LINE_TX_IDLE    = 1;
    localparam int LINE_CTS        = 2;

    // Bit positions inside the multiprocessor status register.
    localparam int MP_NINTH_BIT = 0;
    localparam int MP_NEW_FRAME = 1;

    typedef struct packed {
        logic cts_level;
        logic tx_idle;
        logic hold_empty;
    } line_stat_t;

    typedef struct packed {
        logic new_frame;
        logic ninth_bit;
    } mp_stat_t;

endpackage

// File: rtl/uart_mp_sync.sv
// Module: multi-stage flop synchroniser for one asynchronous level.
// Assumes STAGES >= 2. All flops reset to RST_VAL.
module uart_mp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw input in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Pass the level one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/uart_mp_txhold.sv
// Module: transmit holding register and its empty / idle flags.
// Assumes the engine pulses take only while the holding register is full,
// and holds shift_busy through the stop bit of each character.
module uart_mp_txhold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              take,
    input  logic              shift_busy,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_empty,
    output logic              tx_idle
);

    // Holding byte: updated only by a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_data <= '0;
        else if (load) hold_data <= load_data;
    end

    // Empty flag: a load clears it, a take sets it, and a load wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_empty <= 1'b1;
        else if (load) hold_empty <= 1'b0;
        else if (take) hold_empty <= 1'b1;
    end

    // Idle: nothing waiting and nothing on the line.
    always_comb begin
        tx_idle = hold_empty && !shift_busy;
    end

endmodule

// File: rtl/uart_mp_rxcap.sv
// Module: receive byte capture with ninth-bit and new-frame tracking.
// A character with ninth bit 1 is an address character; it arms a marker so
// that the next character with ninth bit 0 raises new_frame. A host read
// clears the visible flags but leaves the marker; an arrival wins a tie.
module uart_mp_rxcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_mp_bit,
    input  logic              host_read,
    output logic [DATA_W-1:0] rx_byte,
    output logic              ninth_bit,
    output logic              new_frame
);

    logic addr_pending;

    // Received byte: replaced on every arrival.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_byte <= '0;
        else if (rx_strobe) rx_byte <= rx_data;
    end

    // Address marker: armed by an address character, used by the next data one.
    always_ff @(posedge clk) begin
        if (!rst_n)         addr_pending <= 1'b0;
        else if (rx_strobe) addr_pending <= rx_mp_bit;
    end

    // Visible flags: arrival sets them, a host read clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ninth_bit <= 1'b0;
            new_frame <= 1'b0;
        end else if (rx_strobe) begin
            ninth_bit <= rx_mp_bit;
            new_frame <= !rx_mp_bit && addr_pending;
        end else if (host_read) begin
            ninth_bit <= 1'b0;
            new_frame <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_mp_regs.sv
// Module: host register file of a multiprocessor-capable UART.
// Address 0 is write-transmit / read-receive; 1 is line status; 2 is
// multiprocessor status; 3 reads zero. Read data is combinational; side
// effects of a read take place on the clock edge that ends the strobe.
module uart_mp_regs
    import uart_mp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cts_n,
    output logic [DATA_W-1:0] tx_hold_data,
    output logic              tx_hold_full,
    input  logic              tx_take,
    input  logic              tx_shift_busy,
    input  logic              rx_strobe,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_mp_bit
);

    localparam int LINE_W = $bits(line_stat_t);
    localparam int MP_W   = $bits(mp_stat_t);

    logic              wr_data_sel;
    logic              rd_data_sel;
    logic              hold_empty;
    logic              tx_idle;
    logic              cts_level;
    logic [DATA_W-1:0] rx_byte;
    logic              mp_bit;
    logic              new_frame;
    line_stat_t        line_stat;
    mp_stat_t          mp_stat;

    // Decode the access strobes that target the data address.
    always_comb begin
        wr_data_sel = bus_wr && (reg_sel_e'(bus_addr) == SEL_DATA);
        rd_data_sel = bus_rd && (reg_sel_e'(bus_addr) == SEL_DATA);
    end

    uart_mp_txhold #(
        .DATA_W (DATA_W)
    ) i_txhold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_data_sel),
        .load_data  (bus_wdata),
        .take       (tx_take),
        .shift_busy (tx_shift_busy),
        .hold_data  (tx_hold_data),
        .hold_empty (hold_empty),
        .tx_idle    (tx_idle)
    );

    uart_mp_rxcap #(
        .DATA_W (DATA_W)
    ) i_rxcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_strobe (rx_strobe),
        .rx_data   (rx_data),
        .rx_mp_bit (rx_mp_bit),
        .host_read (rd_data_sel),
        .rx_byte   (rx_byte),
        .ninth_bit (mp_bit),
        .new_frame (new_frame)
    );

    uart_mp_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_cts_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cts_n),
        .sync_out (cts_level)
    );

    // Full flag for the engine is the inverse of the host-visible empty flag.
    always_comb begin
        tx_hold_full = !hold_empty;
    end

    // Pack the status fields into their structures.
    always_comb begin
        line_stat.hold_empty = hold_empty;
        line_stat.tx_idle    = tx_idle;
        line_stat.cts_level  = cts_level;
        mp_stat.ninth_bit    = mp_bit;
        mp_stat.new_frame    = new_frame;
    end

    // Read multiplexer: unused bits and the spare address return zero.
    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_addr))
            SEL_DATA:   bus_rdata = rx_byte;
            SEL_LINE:   bus_rdata[LINE_W-1:0] = line_stat;
            SEL_MPSTAT: bus_rdata[MP_W-1:0]   = mp_stat;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_mp_regs_chk.sv
// Module: assertion checker bound to the register file.
module uart_mp_regs_chk
    import uart_mp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] tx_hold_data,
    input logic              tx_take,
    input logic              tx_shift_busy,
    input logic              rx_strobe,
    input logic              rx_mp_bit,
    input logic              hold_empty,
    input logic              mp_bit,
    input logic              new_frame
);

    AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_DATA) |=> !hold_empty); // R1
    AST_TAKE_EMPTIES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && !(bus_wr && bus_addr == SEL_DATA)) |=> hold_empty); // R2
    AST_BUSY_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_LINE && tx_shift_busy) |-> !bus_rdata[LINE_TX_IDLE]); // R3
    AST_NINTH_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> (mp_bit == $past(rx_mp_bit))); // R5
    AST_ADDR_NOT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && rx_mp_bit) |=> !new_frame); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == SEL_DATA && !rx_strobe) |=> (!mp_bit && !new_frame)); // R7
    AST_ARRIVAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == SEL_DATA && rx_strobe && rx_mp_bit) |=> mp_bit); // R8
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_MPSTAT) |-> (bus_rdata[DATA_W-1:2] == '0)); // R9
    AST_HOLD_DATA_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_DATA) |=> (tx_hold_data == $past(bus_wdata))); // R10

endmodule

bind uart_mp_regs uart_mp_regs_chk #(
    .DATA_W (DATA_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .tx_hold_data  (tx_hold_data),
    .tx_take       (tx_take),
    .tx_shift_busy (tx_shift_busy),
    .rx_strobe     (rx_strobe),
    .rx_mp_bit     (rx_mp_bit),
    .hold_empty    (hold_empty),
    .mp_bit        (mp_bit),
    .new_frame     (new_frame)
);

// File: tb/test_uart_mp_regs.sv
// Bench: directed corners plus seeded random traffic against a cycle model.
module test_uart_mp_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cts_n = 1'b1;
    logic [7:0] tx_hold_data;
    logic       tx_hold_full;
    logic       tx_take = 1'b0;
    logic       tx_shift_busy = 1'b0;
    logic       rx_strobe = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_mp_bit = 1'b0;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Bench model state.
    logic       m_empty, m_mp, m_nf, m_arm, m_s1, m_s2;
    logic [7:0] m_rx, m_tx;

    always #2 clk = ~clk;

    uart_mp_regs i_uart_mp_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cts_n(cts_n), .tx_hold_data(tx_hold_data), .tx_hold_full(tx_hold_full),
        .tx_take(tx_take), .tx_shift_busy(tx_shift_busy), .rx_strobe(rx_strobe),
        .rx_data(rx_data), .rx_mp_bit(rx_mp_bit)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_line(input logic busy);
        return {5'b0, m_s2, m_empty && !busy, m_empty};
    endfunction

    function automatic logic [7:0] exp_mpstat();
        return {6'b0, m_nf, m_mp};
    endfunction

    // Model reset values (R1, R3, R4, R5).
    task automatic model_reset();
        m_empty = 1'b1; m_mp = 1'b0; m_nf = 1'b0; m_arm = 1'b0;
        m_s1 = 1'b1; m_s2 = 1'b1; m_rx = '0; m_tx = '0;
    endtask

    // Check whatever the current drives expose, then advance the model one edge.
    task automatic step();
        #1;
        if (bus_rd) begin
            case (bus_addr)
                2'd0: chk("R7 rx byte", bus_rdata, m_rx);
                2'd1: begin
                    chk("R1 hold empty", {7'b0, bus_rdata[0]}, {7'b0, m_empty});
                    chk("R3 tx idle", {7'b0, bus_rdata[1]}, {7'b0, m_empty && !tx_shift_busy});
                    chk("R4 cts level", {7'b0, bus_rdata[2]}, {7'b0, m_s2});
                    chk("R9 line reserved", bus_rdata, exp_line(tx_shift_busy));
                end
                2'd2: begin
                    chk("R5 ninth bit", {7'b0, bus_rdata[0]}, {7'b0, m_mp});
                    chk("R6 new frame", {7'b0, bus_rdata[1]}, {7'b0, m_nf});
                    chk("R9 mp reserved", bus_rdata, exp_mpstat());
                end
                default: chk("R9 spare", bus_rdata, 8'h00);
            endcase
        end
        chk("R10 hold data", tx_hold_data, m_tx);
        chk("R10 hold full", {7'b0, tx_hold_full}, {7'b0, !m_empty});
        // Model edge update.
        if (bus_wr && bus_addr == 2'd0) begin
            m_empty = 1'b0; m_tx = bus_wdata;
        end else if (tx_take) begin
            m_empty = 1'b1;
        end
        if (rx_strobe) begin
            m_rx = rx_data; m_mp = rx_mp_bit;
            m_nf = !rx_mp_bit && m_arm; m_arm = rx_mp_bit;
        end else if (bus_rd && bus_addr == 2'd0) begin
            m_mp = 1'b0; m_nf = 1'b0;
        end
        m_s2 = m_s1; m_s1 = cts_n;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; tx_take = 1'b0; rx_strobe = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        bus_addr = a; bus_rd = 1'b1; step();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d; step();
    endtask

    task automatic rx(input logic [7:0] d, input logic mp);
        rx_strobe = 1'b1; rx_data = d; rx_mp_bit = mp; step();
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state of all registers.
        rd(2'd1); rd(2'd2); rd(2'd0); rd(2'd3);

        // R1: write clears holding empty; R10 data shows up.
        wr(2'd0, 8'hA5); rd(2'd1);
        // R2: take and write together keep it full.
        bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = 8'h3C; tx_take = 1'b1; step();
        rd(2'd1);
        tx_take = 1'b1; step(); rd(2'd1);
        // R3: busy engine with empty holding register is not idle.
        tx_shift_busy = 1'b1; rd(2'd1); tx_shift_busy = 1'b0; rd(2'd1);

        // R9: writes to status addresses change nothing.
        wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd3, 8'hFF); rd(2'd1); rd(2'd2);

        // R6: address char, reads in between, then data char raises new frame.
        rx(8'h11, 1'b1); rd(2'd2); rd(2'd0); rd(2'd2);
        rx(8'h22, 1'b0); rd(2'd2); rd(2'd0); rd(2'd2);
        rx(8'h33, 1'b0); rd(2'd2);
        // R8: read of data colliding with an address character.
        bus_addr = 2'd0; bus_rd = 1'b1; rx_strobe = 1'b1; rx_data = 8'h44; rx_mp_bit = 1'b1;
        step(); rd(2'd2);
        // R8: read colliding with the following data character.
        bus_addr = 2'd0; bus_rd = 1'b1; rx_strobe = 1'b1; rx_data = 8'h55; rx_mp_bit = 1'b0;
        step(); rd(2'd2); rd(2'd0);

        // R4: CTS lags by two edges.
        cts_n = 1'b0; rd(2'd1); rd(2'd1); rd(2'd1);
        cts_n = 1'b1; rd(2'd1); rd(2'd1); rd(2'd1);

        // Random traffic covering R1 to R10.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            bus_addr = r[1:0];
            bus_rd = r[2];
            bus_wr = r[3] && r[4];
            bus_wdata = r[15:8];
            tx_take = r[5] && !m_empty;
            tx_shift_busy = r[6];
            rx_strobe = r[7] && r[16];
            rx_data = r[24:17];
            rx_mp_bit = r[25] && r[26];
            if (r[27] && r[28]) cts_n = r[29];
            step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule